// File: doc/BRIEF.md
# Modem Control and Status Unit

This block holds the modem control register and the modem status register of a 16550-style serial port. The host writes the control register to drive the modem output lines and to select a loopback mode; it reads the status register to see the modem input lines together with four sticky change flags. The block has no modem input pins. In loopback mode the status lines mirror the control outputs. In normal mode they hold fixed levels: carrier detect and data-set-ready high, clear-to-send and ring low.

Every write to the control register compares the line levels before and after the write. Any difference sets the matching change flag, and the flag stays set until the host reads the status register. A read returns the whole status byte and then clears the four flags. The `msc_pending` output is high while any flag is set, and the port's interrupt logic uses it as the modem-status interrupt source. Host reads are registered: the data appears one cycle after the request, with `rd_valid` high.

Top module: `mdm_status_unit`

## Requirements
- R1: A write to the control address stores only wr_data[4:0]: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback enable. A read of the control register returns these five bits, with bits 7..5 read as 0.
- R2: When loopback is enabled, status bit 4 (CTS) follows RTS, bit 5 (DSR) follows DTR, bit 6 (RI) follows OUT1 and bit 7 (DCD) follows OUT2.
- R3: When loopback is disabled, status bits 7..4 read as DCD=1, RI=0, DSR=1, CTS=0, which is 0xA in the upper nibble.
- R4: A control write sets status bit 0 if CTS changes, bit 1 if DSR changes and bit 3 if DCD changes. It sets bit 2 only when RI goes from 1 to 0. Nothing but a control write sets these bits.
- R5: Change bits (status 3..0) are sticky. They accumulate across writes and are never cleared except by a status read.
- R6: A status read returns the full byte as it stood before the read and clears bits 3..0 at the end of that cycle.
- R7: Writes to any address other than the control address, including the status address, change no state.
- R8: After reset the control register is 0x00 and the status register reads 0xA0.
- R9: msc_pending is 1 exactly when any of status bits 3..0 is 1.
- R10: If a status read and a control write happen in the same cycle, the read returns the old byte, the old change bits are cleared, and the changes caused by that write are kept.
- R11: rd_valid is high one cycle after rd_en, and rd_data then holds the addressed register. Any address other than control or status reads 0x00 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Read register address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read data |
| msc_pending | output | 1 | Modem status change pending |

## Verification
The bench targets the RI falling edge. A design that flags every RI change would set bit 2 when OUT1 rises in loopback, and one that ignores the edge would never set it. It writes the status address and checks that control and status do not move. A design that decodes addresses loosely would corrupt the control register or clear the change bits. It issues a status read and a control write in the same cycle. A design with the wrong order of clear and set would either lose the new change bits or return and keep stale ones. It also leaves loopback while the lines are low: a wrong map or wrong fixed levels shows up as missing or extra DSR and DCD change bits.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 5;
  localparam int LIVE_W  = 4;
  localparam int DELTA_W = 4;

  // control register layout, bit 4 down to bit 0
  typedef struct packed {
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } ctrl_t;

  // live status lines, status bits 7..4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } live_t;

  // sticky change flags, status bits 3..0
  typedef struct packed {
    logic ddcd;
    logic teri;
    logic ddsr;
    logic dcts;
  } delta_t;

  // line levels seen by the host for a given control value
  function automatic live_t line_state(input ctrl_t c);
    live_t l;
    if (c.loop) begin
      l.cts = c.rts;
      l.dsr = c.dtr;
      l.ri  = c.out1;
      l.dcd = c.out2;
    end else begin
      l.cts = 1'b0;
      l.dsr = 1'b1;
      l.ri  = 1'b0;
      l.dcd = 1'b1;
    end
    return l;
  endfunction

  // change flags raised by moving from one line state to the next
  function automatic delta_t line_change(input live_t was, input live_t now);
    delta_t d;
    d.dcts = was.cts ^ now.cts;
    d.ddsr = was.dsr ^ now.dsr;
    d.ddcd = was.dcd ^ now.dcd;
    d.teri = was.ri & ~now.ri;
    return d;
  endfunction
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RST_CTRL = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  ctrl_t       din,
  output ctrl_t       ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ctrl_q <= ctrl_t'(RST_CTRL);
    else if (load) ctrl_q <= din;
  end

  // R7: only a control write moves the register
  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ctrl_q));
endmodule

// File: rtl/mdm_line_map.sv
module mdm_line_map
  import mdm_pkg::*;
(
  input  ctrl_t cur_ctrl,
  input  ctrl_t nxt_ctrl,
  output live_t live_cur,
  output live_t live_nxt
);
  always_comb begin
    live_cur = line_state(cur_ctrl);
    live_nxt = line_state(nxt_ctrl);
  end
endmodule

// File: rtl/mdm_delta_trk.sv
module mdm_delta_trk
  import mdm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   set_en,
  input  logic   clr_en,
  input  live_t  live_was,
  input  live_t  live_now,
  output delta_t delta_q
);
  delta_t detected;
  delta_t kept;

  always_comb begin
    detected = set_en ? line_change(live_was, live_now) : '0;
    kept     = clr_en ? '0 : delta_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) delta_q <= '0;
    else        delta_q <= kept | detected;
  end

  // R5: without a clear no flag drops
  assert_delta_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // R6: a clear with no write leaves nothing set
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> (delta_q == '0));

  // R4: no flag rises without a control write
  assert_set_only_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> ((delta_q & ~$past(delta_q)) == '0));
endmodule

// File: rtl/mdm_status_unit.sv
module mdm_status_unit
  import mdm_pkg::*;
#(
  parameter int                  ADDR_W    = 3,
  parameter logic [ADDR_W-1:0]   CTRL_ADDR = 3'd4,
  parameter logic [ADDR_W-1:0]   STAT_ADDR = 3'd6,
  parameter logic [CTRL_W-1:0]   RST_CTRL  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              msc_pending
);
  localparam int PAD_W = DATA_W - CTRL_W;

  // named internal events
  logic   ctrl_wr;
  logic   stat_rd;
  ctrl_t  ctrl_q;
  ctrl_t  ctrl_nxt;
  live_t  live_cur;
  live_t  live_nxt;
  delta_t delta_q;
  logic [DATA_W-1:0] rd_mux;
  logic   unused_hi;

  assign ctrl_wr   = wr_en && (wr_addr == CTRL_ADDR);
  assign stat_rd   = rd_en && (rd_addr == STAT_ADDR);
  assign ctrl_nxt  = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];

  mdm_ctrl_reg #(.RST_CTRL(RST_CTRL)) ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ctrl_wr),
    .din    (ctrl_nxt),
    .ctrl_q (ctrl_q)
  );

  mdm_line_map map_i (
    .cur_ctrl (ctrl_q),
    .nxt_ctrl (ctrl_nxt),
    .live_cur (live_cur),
    .live_nxt (live_nxt)
  );

  mdm_delta_trk delta_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (ctrl_wr),
    .clr_en   (stat_rd),
    .live_was (live_cur),
    .live_now (live_nxt),
    .delta_q  (delta_q)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_addr == CTRL_ADDR)      rd_mux = {{PAD_W{1'b0}}, ctrl_q};
    else if (rd_addr == STAT_ADDR) rd_mux = {live_cur, delta_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : rd_data;
    end
  end

  assign msc_pending = |delta_q;

  // R11: read data one cycle after the request
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R1: control readback has clear upper bits
  assert_ctrl_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == CTRL_ADDR) |=> (rd_data[7:5] == 3'b000));

  // R3: fixed line levels outside loopback
  assert_normal_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.loop |-> (live_cur == 4'b1010));

  // R2: loopback cross-map
  assert_loop_reflect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.loop |-> (live_cur.cts == ctrl_q.rts && live_cur.dsr == ctrl_q.dtr &&
                     live_cur.ri == ctrl_q.out1 && live_cur.dcd == ctrl_q.out2));

  // R4: ring flag rises only on a falling RI
  assert_teri_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_q.teri) |-> ($past(ctrl_wr) && $past(live_cur.ri) && !$past(live_nxt.ri)));

  // R9: pending only rises after a control write
  assert_pending_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msc_pending) |-> $past(ctrl_wr));
endmodule

// File: tb/mdm_status_unit_tb_top.sv
`timescale 1ns/1ps
module mdm_status_unit_tb_top;
  localparam logic [2:0] A_CTRL  = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd6;
  localparam logic [2:0] A_OTHER = 3'd1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       msc_pending;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  byte unsigned exp_q[$];
  string        tag_q[$];

  // bench model
  logic [4:0]   m_ctrl;
  byte unsigned m_delta;

  always #4 clk = ~clk;

  mdm_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .msc_pending(msc_pending)
  );

  function automatic byte unsigned exp_live(input logic [4:0] c);
    byte unsigned v;
    v = 8'h00;
    if (c[4]) begin
      if (c[1]) v = v | 8'h10;
      if (c[0]) v = v | 8'h20;
      if (c[2]) v = v | 8'h40;
      if (c[3]) v = v | 8'h80;
    end else begin
      v = 8'hA0;
    end
    return v;
  endfunction

  function automatic byte unsigned exp_change(input byte unsigned a, input byte unsigned b);
    byte unsigned r;
    byte unsigned x;
    r = 8'h00;
    x = a ^ b;
    if ((x & 8'h10) != 0) r = r | 8'h01;
    if ((x & 8'h20) != 0) r = r | 8'h02;
    if ((a & 8'h40) != 0 && (b & 8'h40) == 0) r = r | 8'h04;
    if ((x & 8'h80) != 0) r = r | 8'h08;
    return r;
  endfunction

  function automatic byte unsigned model_read(input logic [2:0] a);
    if (a == A_CTRL) return {3'b000, m_ctrl};
    if (a == A_STAT) return exp_live(m_ctrl) | m_delta;
    return 8'h00;
  endfunction

  // driver: one cycle of access, expected read pushed to the scoreboard
  task automatic access(input bit w, input logic [2:0] wa, input byte unsigned wd,
                        input bit r, input logic [2:0] ra, input string tag);
    byte unsigned nlive;
    if (r) begin
      exp_q.push_back(model_read(ra));
      tag_q.push_back(tag);
    end
    wr_en = w; wr_addr = wa; wr_data = wd;
    rd_en = r; rd_addr = ra;
    if (r && ra == A_STAT) m_delta = 8'h00;
    if (w && wa == A_CTRL) begin
      nlive   = exp_live(wd[4:0]);
      m_delta = m_delta | exp_change(exp_live(m_ctrl), nlive);
      m_ctrl  = wd[4:0];
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    n_checks++;
    if (msc_pending !== (m_delta != 0)) begin
      n_err++;
      $display("FAIL R9 (%s): msc_pending=%0b expected %0b", tag, msc_pending, (m_delta != 0));
    end
  endtask

  task automatic wr(input logic [2:0] a, input byte unsigned d, input string tag);
    access(1'b1, a, d, 1'b0, A_OTHER, tag);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    access(1'b0, A_OTHER, 8'h00, 1'b1, a, tag);
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rd_valid === 1'b1) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R11: read data %02h with no request, expected none", rd_data);
      end else begin
        byte unsigned e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_err++;
          $display("FAIL %s: rd_data=%02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    m_ctrl = 5'h00; m_delta = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state
    n_checks++;
    if (msc_pending !== 1'b0) begin
      n_err++;
      $display("FAIL R8: msc_pending=%0b expected 0", msc_pending);
    end
    rd(A_CTRL, "R8 ctrl reset");
    rd(A_STAT, "R8 status reset");

    // R1: upper bits dropped, loopback on
    wr(A_CTRL, 8'hFF, "R1 write");
    rd(A_CTRL, "R1 ctrl readback");
    // R2: full reflection plus CTS change
    rd(A_STAT, "R2 loopback all on");
    rd(A_STAT, "R6 flags cleared");

    // R4/R5: all lines drop, flags accumulate
    wr(A_CTRL, 8'h1E, "R4 drop dtr");
    wr(A_CTRL, 8'h10, "R5 drop rest");
    rd(A_STAT, "R5 accumulated");
    rd(A_STAT, "R6 cleared again");

    // R7: write to status and another address is ignored
    wr(A_STAT, 8'h5F, "R7 status write");
    wr(A_OTHER, 8'h0F, "R7 other write");
    rd(A_STAT, "R7 status unchanged");
    rd(A_CTRL, "R7 ctrl unchanged");

    // R4: RI rising sets nothing, falling sets bit 2
    wr(A_CTRL, 8'h14, "R4 ri rise");
    rd(A_STAT, "R4 no teri on rise");
    wr(A_CTRL, 8'h10, "R4 ri fall");
    rd(A_STAT, "R4 teri on fall");

    // R2: single-line maps
    wr(A_CTRL, 8'h12, "R2 rts only");
    rd(A_STAT, "R2 cts from rts");
    wr(A_CTRL, 8'h18, "R2 out2 only");
    rd(A_STAT, "R2 dcd from out2");

    // R10: read and write in the same cycle
    wr(A_CTRL, 8'h11, "R10 setup");
    access(1'b1, A_CTRL, 8'h13, 1'b1, A_STAT, "R10 same-cycle read");
    rd(A_STAT, "R10 new flags kept");

    // R3: leave loopback, fixed levels
    wr(A_CTRL, 8'h10, "R3 lines low");
    rd(A_STAT, "R3 clear");
    wr(A_CTRL, 8'h03, "R3 leave loopback");
    rd(A_STAT, "R3 fixed levels");
    rd(A_STAT, "R3 steady");

    // R11: unmapped address reads zero and clears nothing
    wr(A_CTRL, 8'h13, "R11 setup");
    rd(A_OTHER, "R11 unmapped read");
    rd(A_STAT, "R11 flags survive");

    @(negedge clk);
    @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule